// File: doc/BRIEF.md
# Port Direction and Input-Change Interrupt Logic

This block is the pin-facing half of an eight-bit general-purpose I/O expander. It receives the register contents (direction, output level, input polarity) from the register file and a strobe marking each read of the input byte. It resynchronises the raw pin levels, presents the input byte with optional per-bit inversion, and drives each pad's output enable and data.

A change-detect interrupt watches the input-configured pins. The reference is a copy of the synchronised pins taken at the most recent read of the input byte. The interrupt rises as soon as a watched pin disagrees with that copy. It falls when the pins come back to the copy or when the input byte is read again. The interrupt leaves the block as an open-drain pull-down enable: high means the shared line is pulled low. The bus protocol lives elsewhere.

Top module: `gpio_port_core`

## Requirements
- R1: `in_data` equals the synchronised pin levels XOR `pol_inv`, for every bit and whatever its direction. A pin change applied before clock edge k shows on `in_data` after edge k+1 (two register stages).
- R2: `pin_oe[i]` is 1 when `cfg_dir[i]` is 0 (output) and 0 when `cfg_dir[i]` is 1 (input, high impedance). It follows `cfg_dir` within the same cycle.
- R3: `pin_o[i]` equals `out_val[i]` for output pins and is 0 for input pins, so `out_val` has no effect on input pins.
- R4: After a synchronous reset of at least three cycles, `int_n_oe` is 0 whatever the pin levels are, because the read reference is loaded from the synchronised pins while reset is held.
- R5: `int_n_oe` is 1 while any input-configured synchronised pin differs from the read reference.
- R6: Pins configured as outputs never raise the interrupt, whatever their level.
- R7: The interrupt clears without a read once the input-configured pins return to the reference levels.
- R8: A cycle with `in_rd` high loads the reference from the synchronised pins at that clock edge. The interrupt is 0 after that edge unless the pins move again.
- R9: Turning an output pin into an input raises the interrupt in the same cycle if its synchronised level differs from the reference.
- R10: `pol_inv` does not influence the interrupt; the comparison uses uninverted levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir | input | WIDTH | Direction per pin: 1 input, 0 output |
| out_val | input | WIDTH | Level to drive on output pins |
| pol_inv | input | WIDTH | 1 inverts the matching input byte bit |
| in_rd | input | 1 | Strobe: input byte is being read this cycle |
| pin_i | input | WIDTH | Raw asynchronous pin levels |
| pin_oe | output | WIDTH | Pad driver enable per pin |
| pin_o | output | WIDTH | Pad driver data per pin |
| in_data | output | WIDTH | Input byte after polarity inversion |
| int_n_oe | output | 1 | Open-drain interrupt pull-down enable |

## Verification
A behavioural model with a two-deep history queue and its own reference byte runs beside the design. It is compared with all outputs every cycle. Directed patterns first toggle one input pin and restore it, which separates the self-clearing path from the read-clearing path. Next, reads are taken while pins disagree, which shows that the reference reloads. Then the upper nibble is made outputs with an all-ones output value, and the levels under those pins are changed. This shows that the drive is masked and that output pins cannot interrupt, while the input byte still reflects them. Finally, those pins are switched back to inputs, which must raise the interrupt in that same cycle. Full inversion is applied while the interrupt is idle, to show that polarity never reaches the comparator.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned PORT_W_DEF     = 8;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } pin_dir_e;

    typedef struct packed {
        logic oe;
        logic dout;
    } pad_drv_t;

    function automatic pad_drv_t make_drive(pin_dir_e dir, logic level);
        pad_drv_t d;
        d.oe   = (dir == DIR_OUT);
        d.dout = (dir == DIR_OUT) ? level : 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[LAST];
endmodule

// File: rtl/port_drive.sv
module port_drive
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cfg_dir,
    input  logic [WIDTH-1:0] out_val,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
        pin_dir_e dir;
        pad_drv_t drv;
        assign dir       = pin_dir_e'(cfg_dir[i]);
        assign drv       = make_drive(dir, out_val[i]);
        assign pin_oe[i] = drv.oe;
        assign pin_o[i]  = drv.dout;
    end
endmodule

// File: rtl/change_irq.sv
module change_irq #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] cfg_dir,
    input  logic             in_rd,
    output logic             irq
);
    logic [WIDTH-1:0] ref_q;
    logic [WIDTH-1:0] moved;

    // Reference tracks the pins during reset and reloads on each read.
    always_ff @(posedge clk) begin
        if (rst || in_rd) begin
            ref_q <= pin_s;
        end
    end

    // Only input-direction pins are watched; combinational in cfg_dir.
    assign moved = (pin_s ^ ref_q) & cfg_dir;
    assign irq   = !rst && (|moved);
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH      = PORT_W_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cfg_dir,
    input  logic [WIDTH-1:0] out_val,
    input  logic [WIDTH-1:0] pol_inv,
    input  logic             in_rd,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_o,
    output logic [WIDTH-1:0] in_data,
    output logic             int_n_oe
);
    logic [WIDTH-1:0] pin_s;

    pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d   (pin_i),
        .q   (pin_s)
    );

    port_drive #(.WIDTH(WIDTH)) u_drive (
        .cfg_dir (cfg_dir),
        .out_val (out_val),
        .pin_oe  (pin_oe),
        .pin_o   (pin_o)
    );

    change_irq #(.WIDTH(WIDTH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .pin_s   (pin_s),
        .cfg_dir (cfg_dir),
        .in_rd   (in_rd),
        .irq     (int_n_oe)
    );

    assign in_data = pin_s ^ pol_inv;
endmodule

// File: rtl/gpio_port_core_chk.sv
module gpio_port_core_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] cfg_dir,
    input logic [WIDTH-1:0] pol_inv,
    input logic             in_rd,
    input logic [WIDTH-1:0] pin_s,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_o,
    input logic [WIDTH-1:0] in_data,
    input logic             int_n_oe
);
    AST_INPUT_PINS_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & cfg_dir) == '0) && ((pin_o & cfg_dir) == '0)); // R3

    AST_POL_FLIPS_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
        (pin_s == $past(pin_s)) |-> ((in_data ^ $past(in_data)) == (pol_inv ^ $past(pol_inv)))); // R1

    AST_ALL_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_dir == '0) |-> !int_n_oe); // R6

    AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        in_rd |=> ((pin_s != $past(pin_s)) || !int_n_oe)); // R8

    AST_IRQ_NEEDS_A_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !int_n_oe |=> (!int_n_oe || (pin_s != $past(pin_s)) || (cfg_dir != $past(cfg_dir)))); // R5
endmodule

bind gpio_port_core gpio_port_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_port_core_tb.sv
`timescale 1ns/1ps
module gpio_port_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_dir = 8'hFF;
    logic [7:0] out_val = 8'h00;
    logic [7:0] pol_inv = 8'h00;
    logic       in_rd = 1'b0;
    logic [7:0] pin_i = 8'hA5;
    logic [7:0] pin_oe, pin_o, in_data;
    logic       int_n_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_core u_dut (
        .clk(clk), .rst(rst), .cfg_dir(cfg_dir), .out_val(out_val),
        .pol_inv(pol_inv), .in_rd(in_rd), .pin_i(pin_i),
        .pin_oe(pin_oe), .pin_o(pin_o), .in_data(in_data), .int_n_oe(int_n_oe)
    );

    // Reference model: history of sampled pins and a read reference byte
    logic [7:0] hist[$] = '{8'h00, 8'h00};
    logic [7:0] ref_m = 8'h00;
    int edges = 0;

    always @(posedge clk) begin
        if (rst || in_rd) ref_m = hist[1];
        hist.push_front(pin_i);
        void'(hist.pop_back());
        edges++;
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always begin
        @(negedge clk);
        #2;
        if (edges >= 3 && !done) begin
            chk("R1 in_data model", in_data, hist[1] ^ pol_inv);
            chk("R2 pin_oe model", pin_oe, ~cfg_dir);
            chk("R3 pin_o model", pin_o, out_val & ~cfg_dir);
            chk("R5 irq model", {7'd0, int_n_oe},
                {7'd0, !rst && (|((hist[1] ^ ref_m) & cfg_dir))});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(5);
        rst = 1'b0;
        #1 chk("R4 irq after reset", {7'd0, int_n_oe}, 8'h00);
        // single pin change, two-stage latency
        step(1); pin_i = 8'hA4;
        step(1); #1 chk("R5 irq one edge in", {7'd0, int_n_oe}, 8'h00);
        step(1); #1 chk("R5 irq after sync", {7'd0, int_n_oe}, 8'h01);
        chk("R1 in_data raw", in_data, 8'hA4);
        // return to reference clears without read
        step(1); pin_i = 8'hA5;
        step(2); #1 chk("R7 irq self-clear", {7'd0, int_n_oe}, 8'h00);
        // change again then read
        step(1); pin_i = 8'hA4;
        step(2); #1 chk("R5 irq set again", {7'd0, int_n_oe}, 8'h01);
        step(1); in_rd = 1'b1;
        step(1); in_rd = 1'b0;
        #1 chk("R8 irq cleared by read", {7'd0, int_n_oe}, 8'h00);
        // polarity
        step(1); pol_inv = 8'hFF;
        #1 chk("R1 inverted data", in_data, 8'h5B);
        step(2); #1 chk("R10 polarity no irq", {7'd0, int_n_oe}, 8'h00);
        // upper nibble as outputs
        step(1); cfg_dir = 8'h0F; out_val = 8'hFF;
        #1 chk("R2 pin_oe mixed", pin_oe, 8'hF0);
        chk("R3 pin_o masked", pin_o, 8'hF0);
        step(1); pin_i = 8'h04;
        step(2); #1 chk("R6 output pins silent", {7'd0, int_n_oe}, 8'h00);
        chk("R1 data on output pins", in_data, 8'hFB);
        // back to inputs: immediate interrupt
        step(1); cfg_dir = 8'hFF;
        #1 chk("R9 irq on direction change", {7'd0, int_n_oe}, 8'h01);
        chk("R2 pin_oe all inputs", pin_oe, 8'h00);
        chk("R3 out_val ignored", pin_o, 8'h00);
        step(1); in_rd = 1'b1;
        step(1); in_rd = 1'b0;
        #1 chk("R8 second read clear", {7'd0, int_n_oe}, 8'h00);
        step(3);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule